// File: doc/BRIEF.md
# Balanced-Symbol Packet Transmit Encoder

This block turns one buffered packet into a serial bit stream on a single transmit-data line. Each bit lasts a fixed number of system-clock cycles, set by a divider parameter. A frame goes out in a fixed order:

1. The transmitter enable is lowered, followed by a programmable guard interval.
2. An optional extended wake-up preamble, built from units. Each unit is a run of alternating preamble ended by a hold code.
3. A programmable run of alternating preamble.
4. An eight-bit frame sync word.
5. One DC-balanced 12-bit symbol for every payload byte.
6. One symbol carrying the 8-bit sum of the payload bytes.
7. One quiet tail bit, after which the enable is released and a done pulse is given.

A start pulse launches a frame while the block is idle, and at that moment the frame settings are captured. The payload is fetched through a read-address / read-data pair, which must return the byte combinationally. Each symbol is a 12-bit word with six ones, six zeros and no run longer than four equal bits. The symbol set is the first 256 such words in ascending numeric order, with byte value v mapped to the v-th word. The set is computed at elaboration.

Top module: `symPacketTx`

## Requirements
- R1: After reset, and whenever idle, txEnN is 1, txData is 0 and done is 0.
- R2: A start pulse sampled while idle drives txEnN to 0 at that same clock edge. txData then stays 0 for guardBits bit periods (1..255) before the first preamble bit.
- R3: Each bit lasts exactly DIV clock cycles. txData and txEnN change only at bit boundaries counted from the edge that accepted start.
- R4: The normal preamble is preCycles (1..255) pairs of bits, each pair a 0 followed by a 1.
- R5: The preamble is followed by the sync word 1110_0100, sent MSB first: seven Barker bits and then a 0 as the balancing bit.
- R6: When wakeUnits is non-zero, the guard is followed by wakeUnits units before the normal preamble. Each unit is HOLD_CYCLES pairs of 0,1 followed by the hold code 0001_1011, sent MSB first.
- R7: Payload bytes are read from addresses 0 to pktLen-1 in order. Each byte is sent MSB first as its 12-bit symbol. Every symbol has six ones and no run of more than four equal bits, and no two byte values share a symbol.
- R8: After the payload, the symbol of the payload sum modulo 256 is sent, MSB first.
- R9: After the last checksum bit, one 0 bit is sent with txEnN still 0. At the end of that bit, txEnN returns to 1 and done is 1 for exactly that one cycle.
- R10: Start pulses and changes to preCycles, wakeUnits, guardBits or pktLen while a frame is in progress have no effect on that frame.
- R11: txData is 0 in every cycle where txEnN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a frame when the block is idle |
| preCycles | input | 8 | Number of normal 0,1 preamble pairs |
| wakeUnits | input | 8 | Number of wake-up units; 0 gives no wake-up preamble |
| guardBits | input | 8 | Enable-to-preamble delay, in bit periods |
| pktLen | input | LEN_W | Number of payload bytes (1..MAX_LEN) |
| rdAddr | output | LEN_W | Address of the payload byte to fetch |
| rdData | input | 8 | Payload byte at rdAddr, combinational |
| txData | output | 1 | Serial transmit data |
| txEnN | output | 1 | Transmitter enable, active low |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the block with DIV=4 and HOLD_CYCLES=4, and keeps MAX_LEN=60. The short bit period lets the bench sample both the first and the last cycle of every bit within a small cycle budget. The short wake-up unit lets a frame with several hold codes fit in a few dozen bits. With these settings, sweeping every byte value through full-length packets is cheap. Those sweeps expose every symbol of the table, so the bench can check each one for balance, run length and uniqueness, and can exercise the checksum's modulo-256 wrap.

// File: rtl/encTxPkg.sv
package encTxPkg;

  typedef enum logic [1:0] {BIT_LOW, BIT_PRE, BIT_SHIFT, BIT_LOAD} bitOpE;
  typedef enum logic [1:0] {W_SYNC, W_HOLD, W_BYTE, W_SUM} wordSelE;

  // strobes from control to datapath, valid in the cycle they are raised
  typedef struct packed {
    logic    step;      // emit the next bit on txData
    bitOpE   op;
    wordSelE sel;
    logic    preLevel;  // level used by BIT_PRE
    logic    clearSum;
  } strobeT;

  localparam logic [7:0] SYNC_WORD = 8'b1110_0100;
  localparam logic [7:0] HOLD_WORD = 8'b0001_1011;

  function automatic logic symOk(input logic [11:0] w);
    int ones;
    int run;
    int maxRun;
    ones = 0;
    run = 1;
    maxRun = 1;
    for (int i = 0; i < 12; i++) if (w[i]) ones++;
    for (int i = 1; i < 12; i++) begin
      if (w[i] == w[i-1]) run++;
      else run = 1;
      if (run > maxRun) maxRun = run;
    end
    return (ones == 6) && (maxRun <= 4);
  endfunction

  // first 256 valid words in ascending order; split loop keeps each short
  function automatic logic [255:0][11:0] buildSymbols();
    logic [255:0][11:0] t;
    logic [11:0] w;
    int n;
    t = '0;
    n = 0;
    for (int hi = 0; hi < 64; hi++) begin
      for (int lo = 0; lo < 64; lo++) begin
        w = {hi[5:0], lo[5:0]};
        if (n < 256 && symOk(w)) begin
          t[n] = w;
          n++;
        end
      end
    end
    return t;
  endfunction

  localparam logic [255:0][11:0] SYM_TABLE = buildSymbols();

endpackage

// File: rtl/encTxDatapath.sv
module encTxDatapath
  import encTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     st,
  input  logic [7:0] rdData,
  output logic       txData
);

  logic [11:0] shiftReg;
  logic [7:0]  sum;
  logic [11:0] word;

  always_comb begin
    case (st.sel)
      W_SYNC:  word = {SYNC_WORD, 4'b0000};
      W_HOLD:  word = {HOLD_WORD, 4'b0000};
      W_BYTE:  word = SYM_TABLE[rdData];
      default: word = SYM_TABLE[sum];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sum      <= '0;
      txData   <= 1'b0;
    end else begin
      if (st.clearSum) sum <= '0;
      else if (st.step && st.op == BIT_LOAD && st.sel == W_BYTE) sum <= sum + rdData;
      if (st.step) begin
        case (st.op)
          BIT_LOW:   txData <= 1'b0;
          BIT_PRE:   txData <= st.preLevel;
          BIT_SHIFT: begin
            txData   <= shiftReg[11];
            shiftReg <= {shiftReg[10:0], 1'b0};
          end
          default: begin
            txData   <= word[11];
            shiftReg <= {word[10:0], 1'b0};
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/encTxControl.sv
module encTxControl
  import encTxPkg::*;
#(
  parameter int DIV         = 128,
  parameter int HOLD_CYCLES = 256,
  parameter int LEN_W       = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       preCycles,
  input  logic [7:0]       wakeUnits,
  input  logic [7:0]       guardBits,
  input  logic [LEN_W-1:0] pktLen,
  output strobeT           st,
  output logic [LEN_W-1:0] rdAddr,
  output logic             txEnN,
  output logic             done
);

  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(2 * HOLD_CYCLES + 512);

  typedef enum logic [3:0] {
    S_IDLE, S_GUARD, S_WAKE, S_HOLD, S_PRE, S_SYNC, S_DATA, S_SUM, S_TAIL
  } stateE;

  stateE            state, nextState;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       unitCnt;
  logic [7:0]       preLat, wakeLat, guardLat;
  logic [LEN_W-1:0] lenLat;
  logic             tick, lastBit;

  assign tick  = (state != S_IDLE) && (divCnt == DIV_W'(DIV - 1));
  assign txEnN = (state == S_IDLE);

  always_comb begin
    case (state)
      S_GUARD:        lastBit = (bitCnt + 1'b1) >= CNT_W'(guardLat);
      S_WAKE:         lastBit = bitCnt == CNT_W'(2 * HOLD_CYCLES - 1);
      S_PRE:          lastBit = (bitCnt + 1'b1) >= CNT_W'({preLat, 1'b0});
      S_HOLD, S_SYNC: lastBit = bitCnt == CNT_W'(7);
      S_DATA, S_SUM:  lastBit = bitCnt == CNT_W'(11);
      default:        lastBit = 1'b1;
    endcase
  end

  always_comb begin
    nextState   = state;
    st          = '0;
    st.op       = BIT_LOW;
    st.sel      = W_SYNC;
    if (state == S_IDLE) begin
      if (start) begin
        nextState   = S_GUARD;
        st.step     = 1'b1;
        st.clearSum = 1'b1;
      end
    end else if (tick) begin
      st.step = 1'b1;
      if (!lastBit) begin
        st.preLevel = ~bitCnt[0];
        if (state == S_WAKE || state == S_PRE) st.op = BIT_PRE;
        else if (state == S_GUARD || state == S_TAIL) st.op = BIT_LOW;
        else st.op = BIT_SHIFT;
      end else begin
        case (state)
          S_GUARD: begin
            nextState = (wakeLat != 8'd0) ? S_WAKE : S_PRE;
            st.op     = BIT_PRE;
          end
          S_WAKE: begin
            nextState = S_HOLD;
            st.op     = BIT_LOAD;
            st.sel    = W_HOLD;
          end
          S_HOLD: begin
            nextState = (unitCnt + 8'd1 == wakeLat) ? S_PRE : S_WAKE;
            st.op     = BIT_PRE;
          end
          S_PRE: begin
            nextState = S_SYNC;
            st.op     = BIT_LOAD;
            st.sel    = W_SYNC;
          end
          S_SYNC: begin
            nextState = S_DATA;
            st.op     = BIT_LOAD;
            st.sel    = W_BYTE;
          end
          S_DATA: begin
            st.op = BIT_LOAD;
            if (rdAddr == lenLat) begin
              nextState = S_SUM;
              st.sel    = W_SUM;
            end else begin
              st.sel = W_BYTE;
            end
          end
          S_SUM:   nextState = S_TAIL;
          default: nextState = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      unitCnt  <= '0;
      rdAddr   <= '0;
      preLat   <= '0;
      wakeLat  <= '0;
      guardLat <= '0;
      lenLat   <= '0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == S_TAIL) && tick;
      if (state == S_IDLE) begin
        divCnt <= '0;
        if (start) begin
          preLat   <= preCycles;
          wakeLat  <= wakeUnits;
          guardLat <= guardBits;
          lenLat   <= pktLen;
          bitCnt   <= '0;
          unitCnt  <= '0;
          rdAddr   <= '0;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
          if (state == S_HOLD && lastBit) unitCnt <= unitCnt + 8'd1;
          if (st.op == BIT_LOAD && st.sel == W_BYTE) rdAddr <= rdAddr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/symPacketTx.sv
module symPacketTx
  import encTxPkg::*;
#(
  parameter int DIV         = 128,
  parameter int HOLD_CYCLES = 256,
  parameter int MAX_LEN     = 60,
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       preCycles,
  input  logic [7:0]       wakeUnits,
  input  logic [7:0]       guardBits,
  input  logic [LEN_W-1:0] pktLen,
  output logic [LEN_W-1:0] rdAddr,
  input  logic [7:0]       rdData,
  output logic             txData,
  output logic             txEnN,
  output logic             done
);

  strobeT strobe;

  encTxControl #(.DIV(DIV), .HOLD_CYCLES(HOLD_CYCLES), .LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .preCycles(preCycles), .wakeUnits(wakeUnits), .guardBits(guardBits),
    .pktLen(pktLen), .st(strobe), .rdAddr(rdAddr), .txEnN(txEnN), .done(done)
  );

  encTxDatapath dpath (
    .clk(clk), .rstN(rstN), .st(strobe), .rdData(rdData), .txData(txData)
  );

endmodule

// File: rtl/symPacketTxChk.sv
module symPacketTxChk #(
  parameter int DIV = 128
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic txData,
  input logic txEnN,
  input logic done
);

  localparam int PH_W = $clog2(DIV);
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (txEnN) phase <= '0;
    else phase <= (phase == PH_W'(DIV - 1)) ? '0 : phase + 1'b1;
  end

  // R11
  idle_data_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEnN |-> !txData);

  // R9
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> txEnN);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  enable_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnN) |-> $past(start));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnN && phase != '0) |-> ($stable(txData) && $stable(txEnN)));

  // R3
  release_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnN) |-> phase == '0);

endmodule

bind symPacketTx symPacketTxChk #(.DIV(DIV)) chkInst (
  .clk(clk), .rstN(rstN), .start(start),
  .txData(txData), .txEnN(txEnN), .done(done)
);

// File: tb/symPacketTx_test.sv
`timescale 1ns/1ps
module symPacketTx_test;

  localparam int DIV     = 4;
  localparam int HOLD    = 4;
  localparam int MAX_LEN = 60;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int MAXB    = 4000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [7:0]       preCycles = 8'd1;
  logic [7:0]       wakeUnits = 8'd0;
  logic [7:0]       guardBits = 8'd1;
  logic [LEN_W-1:0] pktLen = '0;
  logic [LEN_W-1:0] rdAddr;
  logic [7:0]       rdData;
  logic             txData, txEnN, done;

  logic [7:0]  pktBuf [0:63];
  logic [11:0] symRef [0:255];
  logic        expBits [0:MAXB-1];
  logic        gotBits [0:MAXB-1];
  logic [11:0] seenSym [0:255];
  logic        seenVal [0:255];
  int nBits;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign rdData = pktBuf[rdAddr];

  symPacketTx #(.DIV(DIV), .HOLD_CYCLES(HOLD), .MAX_LEN(MAX_LEN)) uut (
    .clk(clk), .rstN(rstN), .start(start), .preCycles(preCycles),
    .wakeUnits(wakeUnits), .guardBits(guardBits), .pktLen(pktLen),
    .rdAddr(rdAddr), .rdData(rdData), .txData(txData), .txEnN(txEnN), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic pushWord(input logic [11:0] w, input int cnt);
    for (int k = cnt - 1; k >= 0; k--) begin
      expBits[nBits] = w[k];
      nBits = nBits + 1;
    end
  endtask

  task automatic buildExp(input int guard, input int pre, input int wake, input int len);
    int sum;
    nBits = 0;
    for (int i = 0; i < guard; i++) pushWord(12'd0, 1);
    for (int u = 0; u < wake; u++) begin
      for (int c = 0; c < HOLD; c++) pushWord(12'b01, 2);
      pushWord({4'd0, 8'b0001_1011}, 8);
    end
    for (int c = 0; c < pre; c++) pushWord(12'b01, 2);
    pushWord({4'd0, 8'b1110_0100}, 8);
    sum = 0;
    for (int b = 0; b < len; b++) begin
      pushWord(symRef[pktBuf[b]], 12);
      sum = (sum + int'(pktBuf[b])) % 256;
    end
    pushWord(symRef[sum], 12);
    pushWord(12'd0, 1);
  endtask

  // sends one frame and compares every bit; disturb pokes inputs mid-frame
  task automatic runFrame(input int guard, input int pre, input int wake, input int len,
                          input string req, input bit disturb);
    int badBit, badStable, badCtl, firstBad;
    preCycles = 8'(pre);
    wakeUnits = 8'(wake);
    guardBits = 8'(guard);
    pktLen    = LEN_W'(len);
    buildExp(guard, pre, wake, len);
    badBit = 0; badStable = 0; badCtl = 0; firstBad = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int j = 0; j < nBits; j++) begin
      gotBits[j] = txData;
      if (txData !== expBits[j]) begin
        badBit++;
        if (firstBad < 0) firstBad = j;
      end
      if (txEnN !== 1'b0 || done !== 1'b0) badCtl++;
      if (disturb && j == nBits / 2) begin
        start = 1'b1; preCycles = 8'd9; wakeUnits = 8'd3; guardBits = 8'd7;
        pktLen = LEN_W'(2);
      end
      if (disturb && j == nBits / 2 + 1) start = 1'b0;
      repeat (DIV - 1) @(negedge clk);
      if (txData !== expBits[j] || txEnN !== 1'b0) badStable++;
      @(negedge clk);
    end
    if (firstBad >= 0)
      check(1'b0, req, $sformatf("bit %0d", firstBad), int'(gotBits[firstBad]),
            int'(expBits[firstBad]));
    else check(1'b1, req, "stream", 0, 0);
    // R3 every bit held for DIV cycles
    check(badStable == 0, "R3", "bits changing inside a bit period", badStable, 0);
    // R2 enable low and done quiet across the frame
    check(badCtl == 0, "R2", "enable/done during frame", badCtl, 0);
    // R9 release and done pulse right after the tail bit
    check(txEnN === 1'b1 && done === 1'b1 && txData === 1'b0, "R9", "release {en,done,data}",
          {txEnN, done, txData}, 3'b110);
    @(negedge clk);
    check(done === 1'b0 && txEnN === 1'b1, "R9", "done width {done,en}", {done, txEnN}, 2'b01);
  endtask

  // symbol properties taken from the captured stream of a frame
  task automatic scanSymbols(input int guard, input int pre, input int wake, input int len,
                             output int badW, output int badR);
    int base, ones, run, maxRun;
    logic [11:0] w;
    base = guard + wake * (2 * HOLD + 8) + 2 * pre + 8;
    badW = 0; badR = 0;
    for (int b = 0; b < len; b++) begin
      for (int k = 0; k < 12; k++) w[11 - k] = gotBits[base + 12 * b + k];
      ones = 0; run = 1; maxRun = 1;
      for (int k = 0; k < 12; k++) if (w[k]) ones++;
      for (int k = 1; k < 12; k++) begin
        run = (w[k] == w[k-1]) ? run + 1 : 1;
        if (run > maxRun) maxRun = run;
      end
      if (ones != 6) badW++;
      if (maxRun > 4) badR++;
      seenSym[pktBuf[b]] = w;
      seenVal[pktBuf[b]] = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 completed run");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, badW, badR, totW, totR, dup, missing;
    // reference symbol list from the requirement text
    n = 0;
    for (int w = 0; w < 4096; w++) begin
      int ones, run, maxRun;
      logic [11:0] v;
      v = 12'(w);
      ones = 0; run = 1; maxRun = 1;
      for (int k = 0; k < 12; k++) if (v[k]) ones++;
      for (int k = 1; k < 12; k++) begin
        run = (v[k] == v[k-1]) ? run + 1 : 1;
        if (run > maxRun) maxRun = run;
      end
      if (n < 256 && ones == 6 && maxRun <= 4) begin
        symRef[n] = v;
        n++;
      end
    end
    for (int i = 0; i < 256; i++) seenVal[i] = 1'b0;
    for (int i = 0; i < 64; i++) pktBuf[i] = 8'd0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(txEnN === 1'b1, "R1", "txEnN in reset", int'(txEnN), 1);
    check(txData === 1'b0, "R1", "txData in reset", int'(txData), 0);
    check(done === 1'b0, "R1", "done in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R11 idle line quiet
    check(txEnN === 1'b1 && txData === 1'b0, "R11", "idle {en,data}", {txEnN, txData}, 2'b10);

    // R4 R5 R7 R8 minimal frame
    pktBuf[0] = 8'hA5;
    runFrame(1, 1, 0, 1, "R4/R5/R7/R8 minimal", 1'b0);

    // R7 R8 sweep of all byte values in full-length packets
    totW = 0; totR = 0;
    for (int f = 0; f < 5; f++) begin
      for (int i = 0; i < 60; i++) pktBuf[i] = 8'((f * 60 + i * 7 + f) % 256);
      runFrame(3, 12, 0, 60, "R7 sweep", 1'b0);
      scanSymbols(3, 12, 0, 60, badW, badR);
      totW += badW; totR += badR;
    end
    for (int i = 0; i < 64; i++) pktBuf[i] = 8'(i * 13 + 5);
    runFrame(2, 3, 0, 60, "R7 sweep", 1'b0);
    scanSymbols(2, 3, 0, 60, badW, badR);
    totW += badW; totR += badR;
    // R7 balance and run limit
    check(totW == 0, "R7", "symbols without six ones", totW, 0);
    check(totR == 0, "R7", "symbols with run over four", totR, 0);
    dup = 0; missing = 0;
    for (int a = 0; a < 256; a++) begin
      if (!seenVal[a]) missing++;
      for (int b = a + 1; b < 256; b++)
        if (seenVal[a] && seenVal[b] && seenSym[a] == seenSym[b]) dup++;
    end
    // R7 distinct symbols for every byte value
    check(dup == 0, "R7", "byte values sharing a symbol", dup, 0);
    check(missing == 0, "R7", "byte values not swept", missing, 0);

    // R8 checksum wrap
    for (int i = 0; i < 10; i++) pktBuf[i] = 8'hFF;
    runFrame(1, 2, 0, 10, "R8 checksum wrap", 1'b0);

    // R6 wake-up units with hold codes
    for (int i = 0; i < 4; i++) pktBuf[i] = 8'(8'h30 + i);
    runFrame(2, 2, 2, 4, "R6 wake units", 1'b0);
    runFrame(1, 1, 1, 1, "R6 single unit", 1'b0);

    // R2 long guard, R4 longer preamble
    runFrame(9, 20, 0, 2, "R2/R4 guard and preamble", 1'b0);

    // R10 start and settings changed mid-frame
    for (int i = 0; i < 8; i++) pktBuf[i] = 8'(8'hC0 + 3 * i);
    runFrame(2, 4, 1, 8, "R10 disturbed frame", 1'b1);
    repeat (2 * DIV) @(negedge clk);
    // R10 the held start did not launch a second frame
    check(txEnN === 1'b1, "R10", "no frame after busy start", int'(txEnN), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule